// File: doc/BRIEF.md
# Multichannel Voltage Window Scanner

This block watches up to thirty-five supply rails through a single 8-bit converter. It visits the channels one at a time and steers a two-level analog selector for each one. The first level is five 8-input chips, each with an active-high enable. The second level picks one of those five outputs. For each channel the block waits a settling time and pulses a conversion start. It then polls the converter's active-low ready flag and reads the code. The code is compared against that channel's lower and upper pass limits, and the result is stored as one bit in a fault table.

The table can be read at any time through a combinational address port. A summary indicator is high while any entry holds a fault. A one-cycle done pulse marks the end of each full pass. A scan starts from idle when `scan_en` is high. At the end of a pass the block starts again at once if `scan_en` is still high, and otherwise returns to idle. Limits are written per channel through a small write port. All pins are plain control and status. None of them has back-pressure: the converter handshake is a start pulse followed by the ready flag, and table reads never stall.

Top module: `volt_scan_top`

## Requirements
- R1: A pass converts channels 0 to 34 once each, in ascending order. One clock after channel 34 is recorded, `scan_done` is high for exactly one cycle.
- R2: While channel n is selected, exactly one bit of `chip_sel` is high, bit n/8, and `front_sel` equals n mod 8.
- R3: `back_sel` equals n/8, which is always in the range 0 to 4.
- R4: After the selector lines change, at least `settle_cycles`+1 clock cycles pass before `conv_start` goes high. `conv_start` is high for exactly one cycle.
- R5: `conv_data` is captured only in a cycle where `conv_rdy_n` is low. Polling starts in the cycle after `conv_start`.
- R6: A channel passes when lower ≤ code ≤ upper, with both bounds inclusive. Otherwise its table bit is 1 (fault).
- R7: After reset, every channel has lower limit 183 and upper limit 248. A write with `lim_we` high replaces the limits of channel `lim_ch`.
- R8: Every conversion overwrites that channel's entry. `fault_any` is high exactly when at least one entry is 1.
- R9: If `conv_rdy_n` is not seen low within TMO_CYC (64) cycles of polling, the channel is marked faulty and the scan moves on.
- R10: After reset, all table entries are 0 and `fault_any`, `conv_start` and `scan_done` are 0.
- R11: `rd_fault` shows the entry at `rd_addr` in the same cycle. An address of 35 or more reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Start a pass from idle, or keep scanning at the end of a pass |
| settle_cycles | input | 8 | Extra settling clocks after a select change |
| chip_sel | output | 5 | Front-level chip enables, active high |
| front_sel | output | 3 | Input code within the enabled front chip |
| back_sel | output | 3 | Back-level selector code, 0 to 4 |
| conv_start | output | 1 | One-cycle conversion start |
| conv_rdy_n | input | 1 | Converter ready, active low |
| conv_data | input | 8 | Conversion code, 10 mV per step |
| lim_we | input | 1 | Limit write strobe |
| lim_ch | input | 6 | Channel whose limits are written |
| lim_lo | input | 8 | New lower pass limit |
| lim_hi | input | 8 | New upper pass limit |
| rd_addr | input | 6 | Fault table read address |
| rd_fault | output | 1 | Fault bit at `rd_addr` |
| fault_any | output | 1 | High while any entry is faulty |
| scan_done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The assertions assume that the converter drives `conv_rdy_n` high at the clock edge where it sees `conv_start`, and keeps it high until the code is valid. They also assume that `lim_ch` is either a valid channel or is ignored. The converter model in the bench follows both rules: it raises the flag when it sees the start pulse, and it drives a junk code until it lowers the flag. A channel marked as hung simply never lowers the flag. Limit writes and table reads happen only while the block is idle, so every entry checked in a pass comes from that pass alone.

// File: rtl/scan_pkg.sv
package scan_pkg;
  parameter int NCH      = 35;
  parameter int DW       = 8;
  parameter int PER_CHIP = 8;
  localparam int CHW     = $clog2(NCH);
  localparam int NCHIP   = (NCH + PER_CHIP - 1) / PER_CHIP;
  localparam int FW      = $clog2(PER_CHIP);
  localparam int BW      = CHW - FW;

  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_START, S_WAIT, S_LOG
  } seq_state_t;
endpackage

// File: rtl/scan_mux_map.sv
module scan_mux_map
  import scan_pkg::*;
(
  input  logic [CHW-1:0]   ch,
  output logic [NCHIP-1:0] chip_sel,
  output logic [FW-1:0]    front_sel,
  output logic [BW-1:0]    back_sel
);
  assign front_sel = ch[FW-1:0];
  assign back_sel  = ch[CHW-1:FW];

  for (genvar g = 0; g < NCHIP; g++) begin : g_chip
    assign chip_sel[g] = (ch[CHW-1:FW] == BW'(g));
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int SETTLE_W = 8,
  parameter int TMO_CYC  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_en,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                conv_rdy_n,
  input  logic [DW-1:0]       conv_data,
  output logic [CHW-1:0]      ch,
  output logic                conv_start,
  output logic                res_vld,
  output logic [DW-1:0]       res_data,
  output logic                res_tmo,
  output logic                scan_done
);
  localparam int TW   = $clog2(TMO_CYC + 1);
  localparam int CNTW = (TW > SETTLE_W) ? TW : SETTLE_W;

  seq_state_t      state;
  logic [CNTW-1:0] cnt;

  assign conv_start = (state == S_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ch        <= '0;
      cnt       <= '0;
      res_vld   <= 1'b0;
      res_data  <= '0;
      res_tmo   <= 1'b0;
      scan_done <= 1'b0;
    end else begin
      res_vld   <= 1'b0;
      scan_done <= 1'b0;
      case (state)
        S_IDLE: if (scan_en) begin
          ch    <= '0;
          cnt   <= '0;
          state <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt >= CNTW'(settle_cycles)) begin
            cnt   <= '0;
            state <= S_START;
          end else cnt <= cnt + 1'b1;
        end
        S_START: begin
          cnt   <= '0;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (!conv_rdy_n) begin
            res_data <= conv_data;
            res_tmo  <= 1'b0;
            res_vld  <= 1'b1;
            state    <= S_LOG;
          end else if (cnt == CNTW'(TMO_CYC - 1)) begin
            res_data <= '0;
            res_tmo  <= 1'b1;
            res_vld  <= 1'b1;
            state    <= S_LOG;
          end else cnt <= cnt + 1'b1;
        end
        S_LOG: begin
          cnt <= '0;
          if (ch == CHW'(NCH - 1)) begin
            scan_done <= 1'b1;
            ch        <= '0;
            state     <= scan_en ? S_SETTLE : S_IDLE;
          end else begin
            ch    <= ch + 1'b1;
            state <= S_SETTLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: channel index never leaves the populated range
  p_ch_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ch < CHW'(NCH));
  // R1: end-of-pass strobe lasts one cycle
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);
  // R4: start is a single-cycle pulse
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R4: select lines hold still around a start
  p_sel_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $stable(ch));
  // R5: a non-timeout result is only produced after a low ready flag
  p_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_tmo) |-> $past(!conv_rdy_n));
endmodule

// File: rtl/scan_fault_table.sv
module scan_fault_table
  import scan_pkg::*;
#(
  parameter logic [7:0] DEF_LO = 8'd183,
  parameter logic [7:0] DEF_HI = 8'd248
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lim_we,
  input  logic [CHW-1:0] lim_ch,
  input  logic [DW-1:0]  lim_lo,
  input  logic [DW-1:0]  lim_hi,
  input  logic           res_vld,
  input  logic [CHW-1:0] res_ch,
  input  logic [DW-1:0]  res_data,
  input  logic           res_tmo,
  input  logic [CHW-1:0] rd_addr,
  output logic           rd_fault,
  output logic           fault_any
);
  logic [DW-1:0]  lo_q [NCH];
  logic [DW-1:0]  hi_q [NCH];
  logic [NCH-1:0] fault_q;
  logic           fail;

  assign fail = res_tmo || (res_data < lo_q[res_ch]) || (res_data > hi_q[res_ch]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        lo_q[i] <= DW'(DEF_LO);
        hi_q[i] <= DW'(DEF_HI);
      end
    end else if (lim_we && (lim_ch < CHW'(NCH))) begin
      lo_q[lim_ch] <= lim_lo;
      hi_q[lim_ch] <= lim_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= '0;
    else if (res_vld) fault_q[res_ch] <= fail;
  end

  assign fault_any = |fault_q;
  assign rd_fault  = (rd_addr < CHW'(NCH)) ? fault_q[rd_addr] : 1'b0;

  // R8: a failing result raises the summary indicator
  p_fail_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && fail) |=> fault_any);
  // R9: a timed-out channel is recorded as faulty
  p_tmo_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_tmo) |=> fault_q[$past(res_ch)]);
  // R6: an in-window result clears the entry
  p_pass_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !fail) |=> !fault_q[$past(res_ch)]);
endmodule

// File: rtl/volt_scan_top.sv
module volt_scan_top
  import scan_pkg::*;
#(
  parameter int SETTLE_W = 8,
  parameter int TMO_CYC  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_en,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [NCHIP-1:0]    chip_sel,
  output logic [FW-1:0]       front_sel,
  output logic [BW-1:0]       back_sel,
  output logic                conv_start,
  input  logic                conv_rdy_n,
  input  logic [DW-1:0]       conv_data,
  input  logic                lim_we,
  input  logic [CHW-1:0]      lim_ch,
  input  logic [DW-1:0]       lim_lo,
  input  logic [DW-1:0]       lim_hi,
  input  logic [CHW-1:0]      rd_addr,
  output logic                rd_fault,
  output logic                fault_any,
  output logic                scan_done
);
  logic [CHW-1:0] ch;
  logic           res_vld;
  logic [DW-1:0]  res_data;
  logic           res_tmo;

  scan_seq #(.SETTLE_W(SETTLE_W), .TMO_CYC(TMO_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .settle_cycles(settle_cycles),
    .conv_rdy_n(conv_rdy_n), .conv_data(conv_data), .ch(ch),
    .conv_start(conv_start), .res_vld(res_vld), .res_data(res_data),
    .res_tmo(res_tmo), .scan_done(scan_done)
  );

  scan_mux_map u_map (
    .ch(ch), .chip_sel(chip_sel), .front_sel(front_sel), .back_sel(back_sel)
  );

  scan_fault_table u_tab (
    .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_ch(lim_ch),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .res_vld(res_vld), .res_ch(ch),
    .res_data(res_data), .res_tmo(res_tmo), .rd_addr(rd_addr),
    .rd_fault(rd_fault), .fault_any(fault_any)
  );

  // R2: one front chip enabled, matching the back-level code
  p_chip_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(chip_sel) == 1) && chip_sel[back_sel]);
  // R3: back-level code stays within the five front chips
  p_back_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    back_sel < BW'(NCHIP));
endmodule

// File: tb/sim_volt_scan_top.sv
`timescale 1ns/1ps
module sim_volt_scan_top;
  localparam int N = 35;
  localparam int LAT = 6;

  logic clk = 0, rst_n = 0, scan_en = 0;
  logic [7:0] settle_cycles = 8'd3;
  logic [4:0] chip_sel;
  logic [2:0] front_sel, back_sel;
  logic conv_start, conv_rdy_n = 1'b0;
  logic [7:0] conv_data = 8'h00;
  logic lim_we = 0;
  logic [5:0] lim_ch = 0, rd_addr = 0;
  logic [7:0] lim_lo = 0, lim_hi = 0;
  logic rd_fault, fault_any, scan_done;

  always #4 clk = ~clk;

  volt_scan_top u0 (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .settle_cycles(settle_cycles),
    .chip_sel(chip_sel), .front_sel(front_sel), .back_sel(back_sel),
    .conv_start(conv_start), .conv_rdy_n(conv_rdy_n), .conv_data(conv_data),
    .lim_we(lim_we), .lim_ch(lim_ch), .lim_lo(lim_lo), .lim_hi(lim_hi),
    .rd_addr(rd_addr), .rd_fault(rd_fault), .fault_any(fault_any),
    .scan_done(scan_done)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] volts [N];
  bit hang [N];
  logic [7:0] m_lo [N], m_hi [N];
  logic [N-1:0] exp_q [$];
  bit mon_done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model with mapping, ordering and settling checks
  int exp_ch = 0, mm_err = 0, order_err = 0, settle_err = 0, since = 0, cur = 0, lat = 0;
  bit pending = 0;
  logic [10:0] prev_sel = '0;
  always @(posedge clk) begin
    if ({chip_sel, front_sel, back_sel} != prev_sel) since = 1;
    else since++;
    prev_sel = {chip_sel, front_sel, back_sel};
    if (conv_start) begin
      cur = int'(back_sel) * 8 + int'(front_sel);
      if (chip_sel != (5'd1 << back_sel) || back_sel > 3'd4) mm_err++;
      if (cur != exp_ch) order_err++;
      if (since < int'(settle_cycles) + 1) settle_err++;
      exp_ch++;
      pending = 1; lat = 0;
      conv_rdy_n <= 1'b1;
      conv_data  <= 8'h00;
    end else if (pending && cur < N && !hang[cur]) begin
      lat++;
      if (lat == LAT) begin
        conv_rdy_n <= 1'b0;
        conv_data  <= volts[cur];
        pending = 0;
      end
    end
  end

  task automatic set_lim(input int c, input int lo, input int hi);
    @(negedge clk);
    lim_we = 1; lim_ch = 6'(c); lim_lo = 8'(lo); lim_hi = 8'(hi);
    @(negedge clk);
    lim_we = 0;
    m_lo[c] = 8'(lo); m_hi[c] = 8'(hi);
  endtask

  // driver: predict the table, push it, run one pass
  task automatic run_scan();
    logic [N-1:0] e;
    for (int i = 0; i < N; i++)
      e[i] = hang[i] || volts[i] < m_lo[i] || volts[i] > m_hi[i];
    exp_q.push_back(e);
    @(negedge clk);
    exp_ch = 0; mm_err = 0; order_err = 0; settle_err = 0; mon_done = 0;
    scan_en = 1;
    @(negedge clk);
    scan_en = 0;
    wait (mon_done);
  endtask

  // monitor: on end of pass, pop prediction and compare through the read port
  initial begin
    forever begin
      @(posedge clk);
      if (scan_done) begin
        logic [N-1:0] e;
        @(negedge clk);
        check(!scan_done, "R1 done pulse width", scan_done, 0);
        e = exp_q.pop_front();
        check(exp_ch == N && order_err == 0, "R1 channel order", order_err, 0);
        check(mm_err == 0, "R2/R3 select mapping", mm_err, 0);
        check(settle_err == 0, "R4 settling", settle_err, 0);
        for (int i = 0; i < N; i++) begin
          rd_addr = 6'(i);
          #1;
          check(rd_fault == e[i], hang[i] ? "R9 timeout entry" : "R5/R6 entry", rd_fault, e[i]);
        end
        check(fault_any == (e != '0), "R8 fault_any", fault_any, e != '0);
        mon_done = 1;
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      volts[i] = 8'd200; hang[i] = 0; m_lo[i] = 8'd183; m_hi[i] = 8'd248;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check(fault_any == 0, "R10 fault_any", fault_any, 0);
    check(scan_done == 0 && conv_start == 0, "R10 strobes", {scan_done, conv_start}, 0);
    rd_addr = 6'd5; #1;
    check(rd_fault == 0, "R10 table clear", rd_fault, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(conv_start == 0, "R1 idle without scan_en", conv_start, 0);

    // nominal pass
    run_scan();
    // R7 default limits at the boundaries
    volts[0] = 8'd183; volts[1] = 8'd182; volts[2] = 8'd248; volts[3] = 8'd249;
    volts[8] = 8'd255; volts[34] = 8'd0;
    run_scan();
    // R7 programmed limits, R6 inclusive bounds
    set_lim(5, 10, 20); set_lim(6, 10, 20); set_lim(9, 15, 15);
    volts[5] = 8'd10; volts[6] = 8'd21; volts[9] = 8'd15;
    settle_cycles = 8'd0;
    run_scan();
    // R9 timeout, R8 overwrite of old faults
    volts[1] = 8'd200; volts[3] = 8'd200; hang[7] = 1; hang[34] = 1;
    settle_cycles = 8'd7;
    run_scan();
    // R8 everything back in window clears the indicator
    for (int i = 0; i < N; i++) begin hang[i] = 0; volts[i] = 8'd200; end
    volts[5] = 8'd20; volts[6] = 8'd11; volts[9] = 8'd15;
    run_scan();
    // R11 out-of-range read
    rd_addr = 6'd40; #1;
    check(rd_fault == 0, "R11 out-of-range read", rd_fault, 0);
    rd_addr = 6'd63; #1;
    check(rd_fault == 0, "R11 top address", rd_fault, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule